// File: doc/BRIEF.md
# Clock Primitive Reconfiguration Sequencer

This block reprograms a clock synthesis primitive through its dynamic reconfiguration port, a simple register port with a one-cycle request strobe, a write flag, an address, write and read data, and a ready acknowledge. A controller supplies three divider values and two 32-bit words. The divider values are the output divider, the reference (input) divider and the feedback multiplier. One word carries the lock-detector settings and the other carries the loop-filter settings. A one-cycle `start` pulse launches the sequence.

Each divider is split into a high count, a low count, an odd-value flag and a bypass flag. The block then updates ten primitive registers, one after another, in a fixed order. Every update touches only the bits selected by that register's mask. When the mask is not all ones, the update is a read-modify-write: the block reads the register, keeps the bits outside the mask and substitutes the masked bits. `busy` covers the whole run and `done` marks its end.

Top module: `clkcfg_seq`

## Requirements
- R1: A divider N is encoded as high = floor(N/2) and low = N − high. Register 0x08 receives (high<<6)|low of the output divider under mask 0xEFFF. Register 0x14 receives the same layout for the feedback multiplier under mask 0xEFFF. Register 0x16 carries (high<<6)|low of the reference divider in its low bits.
- R2: The odd flag is N mod 2 and the bypass flag is 1 only when N equals 1. Registers 0x09 (output divider) and 0x15 (feedback) receive (odd<<7)|(bypass<<6) under mask 0x03FF. Register 0x16 receives (odd<<13)|(bypass<<12)|(high<<6)|low of the reference divider under mask 0x3FFF.
- R3: The ten registers are updated in the order 0x08, 0x09, 0x16, 0x14, 0x15, 0x18, 0x19, 0x1A, 0x4E, 0x4F.
- R4: The lock word is placed as follows. Register 0x18 gets bits [9:0] under mask 0x03FF. Register 0x19 gets (bits[20:16]<<10)|0x001 under mask 0x7FFF. Register 0x1A gets (bits[28:24]<<10)|0x3E9 under mask 0x7FFF.
- R5: The filter word is placed as follows. Register 0x4E gets bits [31:16] and register 0x4F gets bits [15:0], both under mask 0x9900.
- R6: Every update whose mask is not 0xFFFF first reads the same address (write flag low). It then writes (read value & ~mask) | (value & mask), so bits outside the mask keep their prior contents.
- R7: Only one port access is outstanding at a time. The request strobe lasts one cycle, and the next request is issued only after the ready for the previous one has been seen.
- R8: `busy` rises in the cycle after an accepted `start`. It stays high until the ready of the final write is taken.
- R9: `done` is high for exactly one cycle, in the cycle after the final write's ready, with `busy` already low.
- R10: A `start` pulse while `busy` is high has no effect. The running sequence keeps the values latched at launch, and no extra accesses follow.
- R11: After reset `busy`, `done` and the request strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, sampled when idle |
| out_div | input | 8 | Output divider value |
| ref_div | input | 8 | Reference divider value |
| fb_div | input | 8 | Feedback multiplier value |
| lock_word | input | 32 | Lock-detector settings word |
| filt_word | input | 32 | Loop-filter settings word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| drp_en | output | 1 | Port request strobe |
| drp_we | output | 1 | Port write flag |
| drp_addr | output | 7 | Port register address |
| drp_di | output | 16 | Data written to the primitive |
| drp_do | input | 16 | Data read from the primitive |
| drp_rdy | input | 1 | Access acknowledge from the primitive |

## Verification
The bench builds the block with its default widths: 8-bit dividers, a 7-bit address and 16-bit data. These widths cover the extreme divider values 1, 2, 80 and 128. At 128 the high count spills into a masked-off bit. A bench-side register model answers with a ready latency of one, two or three cycles, set per scenario. The model is pre-filled with a per-address pattern, so each merge shows whether the bits outside the mask survived. One scenario changes every input and pulses `start` in the middle of a run, to show the latched values win.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int DIV_W   = 8;
    localparam int CFG_W   = 32;
    localparam int DRP_AW  = 7;
    localparam int DRP_DW  = 16;
    localparam int N_STEPS = 10;
    localparam int STEP_W  = $clog2(N_STEPS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT
    } seq_state_t;

    typedef struct packed {
        logic [DIV_W-1:0] hi;
        logic [DIV_W-1:0] lo;
        logic             odd;
        logic             bypass;
    } div_fields_t;

    typedef struct packed {
        seq_state_t         st;
        logic [STEP_W-1:0]  step;
        logic [DIV_W-1:0]   out_div;
        logic [DIV_W-1:0]   ref_div;
        logic [DIV_W-1:0]   fb_div;
        logic [CFG_W-1:0]   lock;
        logic [CFG_W-1:0]   filt;
        logic [DRP_DW-1:0]  wdata;
        logic               done;
    } seq_regs_t;

    // Bits of each target register owned by the sequencer, by step.
    function automatic logic [DRP_DW-1:0] step_mask(input logic [STEP_W-1:0] s);
        case (int'(s))
            0, 3:    step_mask = 16'hEFFF;
            1, 4:    step_mask = 16'h03FF;
            2:       step_mask = 16'h3FFF;
            5:       step_mask = 16'h03FF;
            6, 7:    step_mask = 16'h7FFF;
            8, 9:    step_mask = 16'h9900;
            default: step_mask = 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/clkcfg_div_enc.sv
module clkcfg_div_enc
    import clkcfg_pkg::*;
(
    input  logic [DIV_W-1:0] div_i,
    output div_fields_t      fld_o
);
    logic [DIV_W-1:0] half;

    always_comb begin
        half         = div_i >> 1;
        fld_o.hi     = half;
        fld_o.lo     = div_i - half;
        fld_o.odd    = div_i[0];
        fld_o.bypass = (div_i == DIV_W'(1));
    end
endmodule

// File: rtl/clkcfg_step_tab.sv
module clkcfg_step_tab
    import clkcfg_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  div_fields_t       out_f,
    input  div_fields_t       ref_f,
    input  div_fields_t       fb_f,
    input  logic [CFG_W-1:0]  lock_i,
    input  logic [CFG_W-1:0]  filt_i,
    output logic [DRP_AW-1:0] addr_o,
    output logic [DRP_DW-1:0] val_o,
    output logic [DRP_DW-1:0] mask_o
);
    function automatic logic [DRP_DW-1:0] counts(input div_fields_t f);
        counts = (DRP_DW'(f.hi) << 6) | DRP_DW'(f.lo);
    endfunction

    function automatic logic [DRP_DW-1:0] flags(input div_fields_t f);
        flags = {8'h00, f.odd, f.bypass, 6'h00};
    endfunction

    logic unused_lock_bits;
    assign unused_lock_bits = ^{lock_i[15:10], lock_i[23:21], lock_i[31:29]};

    always_comb begin
        mask_o = step_mask(step_i);
        case (int'(step_i))
            0: begin addr_o = 7'h08; val_o = counts(out_f); end
            1: begin addr_o = 7'h09; val_o = flags(out_f); end
            2: begin
                addr_o = 7'h16;
                val_o  = {2'b00, ref_f.odd, ref_f.bypass, 12'h000} | counts(ref_f);
            end
            3: begin addr_o = 7'h14; val_o = counts(fb_f); end
            4: begin addr_o = 7'h15; val_o = flags(fb_f); end
            5: begin addr_o = 7'h18; val_o = {6'h00, lock_i[9:0]}; end
            6: begin addr_o = 7'h19; val_o = {1'b0, lock_i[20:16], 10'h001}; end
            7: begin addr_o = 7'h1A; val_o = {1'b0, lock_i[28:24], 10'h3E9}; end
            8: begin addr_o = 7'h4E; val_o = filt_i[31:16]; end
            9: begin addr_o = 7'h4F; val_o = filt_i[15:0]; end
            default: begin addr_o = '0; val_o = '0; end
        endcase
    end
endmodule

// File: rtl/clkcfg_seq.sv
module clkcfg_seq
    import clkcfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [DIV_W-1:0]      out_div,
    input  logic [DIV_W-1:0]      ref_div,
    input  logic [DIV_W-1:0]      fb_div,
    input  logic [CFG_W-1:0]      lock_word,
    input  logic [CFG_W-1:0]      filt_word,
    output logic                  busy,
    output logic                  done,
    output logic                  drp_en,
    output logic                  drp_we,
    output logic [DRP_AW-1:0]     drp_addr,
    output logic [DRP_DW-1:0]     drp_di,
    input  logic [DRP_DW-1:0]     drp_do,
    input  logic                  drp_rdy
);
    localparam int N_DIVS = 3;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);
    localparam logic [DRP_DW-1:0] FULL_MASK = '1;

    seq_regs_t r_q, r_d;

    logic [DIV_W-1:0]  div_vals [N_DIVS];
    div_fields_t       div_flds [N_DIVS];
    logic [DRP_AW-1:0] tab_addr;
    logic [DRP_DW-1:0] tab_val;
    logic [DRP_DW-1:0] tab_mask;
    logic [STEP_W-1:0] step_nx;

    assign div_vals[0] = r_q.out_div;
    assign div_vals[1] = r_q.ref_div;
    assign div_vals[2] = r_q.fb_div;

    for (genvar g = 0; g < N_DIVS; g++) begin : g_enc
        clkcfg_div_enc u_enc (
            .div_i (div_vals[g]),
            .fld_o (div_flds[g])
        );
    end

    clkcfg_step_tab u_tab (
        .step_i (r_q.step),
        .out_f  (div_flds[0]),
        .ref_f  (div_flds[1]),
        .fb_f   (div_flds[2]),
        .lock_i (r_q.lock),
        .filt_i (r_q.filt),
        .addr_o (tab_addr),
        .val_o  (tab_val),
        .mask_o (tab_mask)
    );

    assign step_nx = r_q.step + STEP_W'(1);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.out_div = out_div;
                    r_d.ref_div = ref_div;
                    r_d.fb_div  = fb_div;
                    r_d.lock    = lock_word;
                    r_d.filt    = filt_word;
                    r_d.step    = '0;
                    r_d.st      = (step_mask('0) == FULL_MASK) ? ST_WR_REQ : ST_RD_REQ;
                end
            end
            ST_RD_REQ: r_d.st = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (drp_rdy) begin
                    r_d.wdata = (drp_do & ~tab_mask) | (tab_val & tab_mask);
                    r_d.st    = ST_WR_REQ;
                end
            end
            ST_WR_REQ: r_d.st = ST_WR_WAIT;
            ST_WR_WAIT: begin
                if (drp_rdy) begin
                    if (r_q.step == LAST_STEP) begin
                        r_d.st   = ST_IDLE;
                        r_d.step = '0;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.step = step_nx;
                        r_d.st   = (step_mask(step_nx) == FULL_MASK) ? ST_WR_REQ : ST_RD_REQ;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign drp_en   = (r_q.st == ST_RD_REQ) || (r_q.st == ST_WR_REQ);
    assign drp_we   = (r_q.st == ST_WR_REQ);
    assign drp_addr = tab_addr;
    assign drp_di   = (tab_mask == FULL_MASK) ? tab_val : r_q.wdata;
endmodule

// File: rtl/clkcfg_seq_chk.sv
module clkcfg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic drp_en,
    input logic drp_we,
    input logic drp_rdy
);
    logic pend_q;
    logic last_we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            last_we_q <= 1'b0;
        end else begin
            if (drp_en) begin
                pend_q    <= 1'b1;
                last_we_q <= drp_we;
            end else if (drp_rdy) begin
                pend_q <= 1'b0;
            end
        end
    end

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |=> !drp_en);
    assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |-> !pend_q);
    assert_write_is_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drp_we |-> drp_en);
    assert_busy_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_busy_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !drp_rdy) |=> busy);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> last_we_q);
endmodule

bind clkcfg_seq clkcfg_seq_chk u_chk (.*);

// File: tb/tb_clkcfg_seq.sv
module tb_clkcfg_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  out_div = '0, ref_div = '0, fb_div = '0;
    logic [31:0] lock_word = '0, filt_word = '0;
    logic        busy, done, drp_en, drp_we;
    logic [6:0]  drp_addr;
    logic [15:0] drp_di;
    logic [15:0] drp_do = '0;
    logic        drp_rdy = 1'b0;

    int errors = 0;
    int checks = 0;

    always #5ns clk = ~clk;

    clkcfg_seq dut (.*);

    // Register model of the primitive's reconfiguration port.
    logic [15:0] mem [0:127];
    logic [6:0]  log_a [0:63];
    logic        log_w [0:63];
    int          log_n = 0;
    int          lat = 1;
    int          cnt = 0;
    logic [15:0] rbuf = '0;
    int          overlap = 0;

    always @(posedge clk) begin
        drp_rdy <= 1'b0;
        if (cnt > 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                drp_rdy <= 1'b1;
                drp_do  <= rbuf;
            end
        end
        if (drp_en) begin
            if (cnt > 0) overlap <= overlap + 1;
            if (log_n < 64) begin
                log_a[log_n] <= drp_addr;
                log_w[log_n] <= drp_we;
            end
            log_n <= log_n + 1;
            if (drp_we) mem[drp_addr] <= drp_di;
            else        rbuf <= mem[drp_addr];
            cnt <= lat;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] step_addr(input int k);
        case (k)
            0: return 7'h08; 1: return 7'h09; 2: return 7'h16; 3: return 7'h14;
            4: return 7'h15; 5: return 7'h18; 6: return 7'h19; 7: return 7'h1A;
            8: return 7'h4E; default: return 7'h4F;
        endcase
    endfunction

    function automatic logic [15:0] enc_counts(input int n);
        int h = n / 2;
        return 16'((h << 6) | (n - h));
    endfunction

    function automatic logic [15:0] enc_flags(input int n, input int shift);
        int odd = n % 2;
        int byp = (n == 1) ? 1 : 0;
        return 16'((odd << (shift + 1)) | (byp << shift));
    endfunction

    function automatic logic [15:0] exp_val(input int k, input int o, input int r, input int f,
                                            input logic [31:0] lk, input logic [31:0] fl,
                                            output logic [15:0] m);
        case (k)
            0: begin m = 16'hEFFF; return enc_counts(o); end
            1: begin m = 16'h03FF; return enc_flags(o, 6); end
            2: begin m = 16'h3FFF; return enc_flags(r, 12) | enc_counts(r); end
            3: begin m = 16'hEFFF; return enc_counts(f); end
            4: begin m = 16'h03FF; return enc_flags(f, 6); end
            5: begin m = 16'h03FF; return {6'h00, lk[9:0]}; end
            6: begin m = 16'h7FFF; return {1'b0, lk[20:16], 10'h001}; end
            7: begin m = 16'h7FFF; return {1'b0, lk[28:24], 10'h3E9}; end
            8: begin m = 16'h9900; return fl[31:16]; end
            default: begin m = 16'h9900; return fl[15:0]; end
        endcase
    endfunction

    function automatic string step_req(input int k);
        if (k == 0 || k == 3) return "R1";
        if (k <= 4) return "R2";
        if (k <= 7) return "R4";
        return "R5";
    endfunction

    task automatic test_reset();
        @(negedge clk);
        check(busy == 1'b0, "R11", "busy after reset", 32'(busy), 0);
        check(done == 1'b0, "R11", "done after reset", 32'(done), 0);
        check(drp_en == 1'b0, "R11", "strobe after reset", 32'(drp_en), 0);
    endtask

    task automatic run_cfg(input int o, input int r, input int f,
                           input logic [31:0] lk, input logic [31:0] fl,
                           input int lat_i, input bit inject);
        logic [15:0] pre [0:127];
        int done_cnt = 0;
        int cyc = 0;
        int busy_bad = 0;
        int order_bad = 0;
        int rmw_bad = 0;
        for (int i = 0; i < 128; i++) begin
            mem[i] = 16'hA5C3 ^ 16'(i * 16'h0107);
            pre[i] = mem[i];
        end
        lat = lat_i;
        log_n = 0;
        overlap = 0;
        @(negedge clk);
        out_div = 8'(o); ref_div = 8'(r); fb_div = 8'(f);
        lock_word = lk; filt_word = fl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8", "busy after start", 32'(busy), 1);
        while (done_cnt == 0 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 7) begin
                out_div = 8'h03; ref_div = 8'h05; fb_div = 8'h09;
                lock_word = ~lk; filt_word = ~fl;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) begin
                done_cnt++;
                check(busy == 1'b0, "R9", "busy low at done", 32'(busy), 0);
            end else if (!busy) begin
                busy_bad++;
            end
        end
        check(done_cnt == 1, "R9", "done seen", 32'(done_cnt), 1);
        check(busy_bad == 0, "R8", "busy gaps before done", 32'(busy_bad), 0);
        @(negedge clk);
        check(done == 1'b0, "R9", "done width one cycle", 32'(done), 0);
        repeat (6) @(negedge clk);
        check(log_n == 20, inject ? "R10" : "R6", "access count", 32'(log_n), 20);
        check(overlap == 0, "R7", "overlapping requests", 32'(overlap), 0);
        for (int k = 0; k < 10 && k * 2 + 1 < log_n; k++) begin
            if (log_a[2*k] != step_addr(k) || log_a[2*k+1] != step_addr(k)) order_bad++;
            if (log_w[2*k] != 1'b0 || log_w[2*k+1] != 1'b1) rmw_bad++;
        end
        check(order_bad == 0, "R3", "address order mismatches", 32'(order_bad), 0);
        check(rmw_bad == 0, "R6", "read-then-write mismatches", 32'(rmw_bad), 0);
        for (int k = 0; k < 10; k++) begin
            logic [15:0] m;
            logic [15:0] v;
            logic [15:0] e;
            v = exp_val(k, o, r, f, lk, fl, m);
            e = (pre[step_addr(k)] & ~m) | (v & m);
            check(mem[step_addr(k)] == e, inject && k == 0 ? "R10" : step_req(k),
                  $sformatf("reg 0x%0h", step_addr(k)), 32'(mem[step_addr(k)]), 32'(e));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        test_reset();
        run_cfg(5, 1, 10, 32'h1F1F_03E8, 32'h0100_1990, 1, 1'b0);
        run_cfg(1, 3, 7, 32'h0B0B_02EE, 32'h0800_9090, 3, 1'b0);
        run_cfg(128, 80, 64, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, 1'b1);
        run_cfg(2, 2, 2, 32'h0606_0000, 32'h0000_0000, 1, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule